// File: doc/BRIEF.md
# Scatter-Gather Audio DMA Channel

This block is a single audio DMA channel. It follows a list of 8-byte descriptors in memory. Each descriptor names a buffer address and a byte count. For every byte of that buffer, the channel emits one transfer beat that carries the byte address on a valid/ready stream. A data mover downstream of the stream performs the actual sample access. The channel reads each descriptor as two 32-bit words through a request/acknowledge memory port.

Software programs the channel through a four-entry register port: table base, control, status and position. It then starts the channel. Completion events raise sticky status bits, and those bits can drive the interrupt line. Per-descriptor control bits select end-of-list, a flag event, or a stop. With the autostart mode set, the channel reloads the table head after an end-of-list descriptor and runs without pause.

Top module: `sgdma_chan`

## Requirements
- R1: After a start, the channel reads the current descriptor as two words. It reads the buffer address at the descriptor pointer, then the flag/count word at the pointer plus 4. In the flag/count word, bit 31 is end-of-list, bit 30 is flag, bit 29 is stop, and bits 23:0 are the byte count.
- R2: For a count of N, the channel issues exactly N stream beats. The beat addresses run from the buffer address upward in steps of 1. A beat holds its valid and its address until ready is seen.
- R3: Register address 3 reads back the descriptor index in progress in bits 31:24 and the bytes still to move in bits 23:0.
- R4: When a descriptor completes without end-of-list or stop, the next descriptor is fetched at the pointer plus 8, and the index increments.
- R5: When an end-of-list descriptor completes, the sticky end-of-list status (status bit 0) is set. If autostart is clear, the channel goes inactive (status bit 3 low).
- R6: When autostart (control bit 2) is set and an end-of-list descriptor completes, the channel refetches from the table base with index 0 and stays active.
- R7: When a descriptor with the flag bit completes, the sticky flag status (status bit 1) is set.
- R8: When a descriptor with the stop bit completes, the channel goes inactive and sets the flag status. End-of-list status is left clear unless that descriptor also carries end-of-list. In that case autostart is not applied.
- R9: A descriptor with a count of zero completes without any stream beat.
- R10: The interrupt output is (end-of-list status AND control bit 3) OR (flag status AND control bit 4). It is mirrored in status bit 2. It stays high until software writes 1 to the set status bits, which clears them.
- R11: Writing control with bit 1 (stop) set makes the channel inactive by the next cycle, and no further beats follow. A later write of 0 to control followed by a write with bit 0 (start) runs a new list.
- R12: After reset, the channel is inactive, the interrupt is low, and the control, status and position registers read 0. Register address 0 holds the table base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 control, 2 status, 3 position |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Descriptor word byte address |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Descriptor word |
| beat_valid | output | 1 | Stream beat available |
| beat_addr | output | AW | Byte address of the beat |
| beat_ready | input | 1 | Stream sink accepts the beat |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following behaviours. A stalled beat or an unacknowledged fetch holds its address. Each accepted beat lowers the remaining count by one. A stop write idles the channel on the next cycle. A zero-count descriptor raises no beat. The interrupt stays high while software leaves the registers alone.

The list walk can only be shown by the bench's scenarios. This covers the fetch order, the reload to the table head under autostart, the resulting status bits for flag, stop and end-of-list, and the packed position value during a stall. The bench shows these by comparing logged fetch and beat addresses and register readbacks against values worked out from the descriptor tables.

// File: rtl/sgdma_chan.sv
module sgdma_chan #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          beat_valid,
  output logic [AW-1:0] beat_addr,
  input  logic          beat_ready,
  output logic          irq
);
  localparam int CW = 24;
  localparam int IW = 8;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_CNT, S_MOVE} st_t;
  st_t state;

  logic [AW-1:0] tbl_base, desc_ptr, buf_ptr;
  logic [CW-1:0] remain;
  logic [IW-1:0] idx;
  logic d_eol, d_flag, d_stop;
  logic auto_rs, ie_eol, ie_flag, stop_held;
  logic eol_st, flag_st;

  wire wr_base = reg_wr && reg_addr == 2'd0;
  wire wr_ctrl = reg_wr && reg_addr == 2'd1;
  wire wr_stat = reg_wr && reg_addr == 2'd2;
  wire active  = state != S_IDLE;
  wire fire    = beat_valid && beat_ready;

  assign mem_req    = state == S_ADDR || state == S_CNT;
  assign mem_addr   = (state == S_CNT) ? desc_ptr + AW'(4) : desc_ptr;
  assign beat_valid = state == S_MOVE && remain != '0;
  assign beat_addr  = buf_ptr;
  assign irq        = (eol_st && ie_eol) || (flag_st && ie_flag);

  logic unused_bits;
  assign unused_bits = ^mem_rdata[28:24];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(tbl_base);
      2'd1:    reg_rdata = {27'd0, ie_flag, ie_eol, auto_rs, stop_held, 1'b0};
      2'd2:    reg_rdata = {28'd0, active, irq, flag_st, eol_st};
      default: reg_rdata = {idx, remain};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tbl_base <= '0; desc_ptr <= '0; buf_ptr <= '0;
      remain <= '0; idx <= '0;
      d_eol <= 1'b0; d_flag <= 1'b0; d_stop <= 1'b0;
      auto_rs <= 1'b0; ie_eol <= 1'b0; ie_flag <= 1'b0; stop_held <= 1'b0;
      eol_st <= 1'b0; flag_st <= 1'b0;
    end else begin
      if (wr_stat) begin
        if (reg_wdata[0]) eol_st  <= 1'b0;
        if (reg_wdata[1]) flag_st <= 1'b0;
      end
      if (wr_base) tbl_base <= reg_wdata[AW-1:0];

      case (state)
        S_ADDR: if (mem_ack) begin
          buf_ptr <= mem_rdata[AW-1:0];
          state   <= S_CNT;
        end
        S_CNT: if (mem_ack) begin
          d_eol  <= mem_rdata[31];
          d_flag <= mem_rdata[30];
          d_stop <= mem_rdata[29];
          remain <= mem_rdata[CW-1:0];
          state  <= S_MOVE;
        end
        S_MOVE: if (fire) begin
          buf_ptr <= buf_ptr + AW'(1);
          remain  <= remain - CW'(1);
        end else if (remain == '0) begin
          if (d_flag || d_stop) flag_st <= 1'b1;
          if (d_eol) eol_st <= 1'b1;
          if (d_stop) state <= S_IDLE;
          else if (d_eol) begin
            if (auto_rs) begin
              desc_ptr <= tbl_base;
              idx      <= '0;
              state    <= S_ADDR;
            end else state <= S_IDLE;
          end else begin
            desc_ptr <= desc_ptr + AW'(8);
            idx      <= idx + IW'(1);
            state    <= S_ADDR;
          end
        end
        default: ;
      endcase

      if (wr_ctrl) begin
        stop_held <= reg_wdata[1];
        auto_rs   <= reg_wdata[2];
        ie_eol    <= reg_wdata[3];
        ie_flag   <= reg_wdata[4];
        if (reg_wdata[1]) state <= S_IDLE;
        else if (reg_wdata[0]) begin
          state    <= S_ADDR;
          desc_ptr <= tbl_base;
          idx      <= '0;
          remain   <= '0;
        end
      end
    end
  end

  assert_fetch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !reg_wr |=> mem_req && $stable(mem_addr));

  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && !reg_wr |=> beat_valid && $stable(beat_addr));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !wr_ctrl |=> remain == $past(remain) - CW'(1));

  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CNT && mem_ack && mem_rdata[CW-1:0] == '0 && !reg_wr |=> !beat_valid);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !reg_wr |=> irq);

  assert_stop_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && reg_wdata[1] |=> !active && !beat_valid);
endmodule

// File: tb/sim_sgdma_chan.sv
module sim_sgdma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic beat_valid, beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic irq;

  sgdma_chan #(.AW(32)) u0 (.*);

  always #5 clk = ~clk;

  localparam logic [31:0] EOL = 32'h8000_0000, FLG = 32'h4000_0000, STP = 32'h2000_0000;

  logic [31:0] mem [0:63];
  logic [31:0] blog [0:63];
  logic [31:0] flog [0:63];
  int nb = 0, nf = 0, budget = 1000000;
  bit stall = 0, tog = 0;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr[7:2]];
        if (nf < 64) flog[nf] = mem_addr;
        nf++;
      end else mem_ack = 1'b0;
      begin
        logic nr;
        nr = (budget > 0) && (!stall || tog);
        tog = ~tog;
        if (beat_valid && nr) begin
          if (nb < 64) blog[nb] = beat_addr;
          nb++;
          budget--;
        end
        beat_ready = nr;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, s);
      if (!s[3]) break;
    end
  endtask

  task automatic put(input int tab, input int i, input logic [31:0] b, input logic [31:0] fc);
    mem[(tab >> 2) + 2*i]     = b;
    mem[(tab >> 2) + 2*i + 1] = fc;
  endtask

  task automatic prep(input int tab);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h3);
    wr(2'd0, 32'(tab));
    nb = 0; nf = 0; budget = 1000000; stall = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd1, v); chk("R12 control", v, 32'h0);
    rd(2'd2, v); chk("R12 status", v, 32'h0);
    rd(2'd3, v); chk("R12 position", v, 32'h0);
    chk("R12 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_two_desc();
    logic [31:0] v;
    prep(32'h00);
    put(32'h00, 0, 32'h1000, 32'd3);
    put(32'h00, 1, 32'h2000, EOL | 32'd2);
    stall = 1;
    wr(2'd1, 32'h1);
    wait_idle();
    chk("R2 beat count", 32'(nb), 32'd5);
    chk("R2 beat0", blog[0], 32'h1000);
    chk("R2 beat2", blog[2], 32'h1002);
    chk("R4 beat3 next desc", blog[3], 32'h2000);
    chk("R2 beat4", blog[4], 32'h2001);
    chk("R1 fetch count", 32'(nf), 32'd4);
    chk("R1 fetch addr word", flog[0], 32'h00);
    chk("R1 fetch count word", flog[1], 32'h04);
    chk("R4 next desc at +8", flog[2], 32'h08);
    rd(2'd2, v); chk("R5 eol set, inactive", v, 32'h1);
    rd(2'd3, v); chk("R3 final position", v, 32'h0100_0000);
    chk("R10 irq masked", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_stop_write();
    logic [31:0] v;
    prep(32'h80);
    put(32'h80, 0, 32'h1100, 32'd2);
    put(32'h80, 1, 32'h2100, EOL | 32'd6);
    budget = 4;
    wr(2'd1, 32'h1);
    repeat (30) @(negedge clk);
    rd(2'd3, v); chk("R3 position mid desc", v, 32'h0100_0004);
    wr(2'd1, 32'h2);
    rd(2'd2, v); chk("R11 inactive after stop", v & 32'h8, 32'h0);
    budget = 1000000;
    repeat (20) @(negedge clk);
    chk("R11 no beats after stop", 32'(nb), 32'd4);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R11 control cleared", v, 32'h0);
    put(32'hC0, 0, 32'h2200, EOL | 32'd1);
    wr(2'd0, 32'hC0);
    wr(2'd1, 32'h1);
    wait_idle();
    chk("R11 restart beat count", 32'(nb), 32'd5);
    chk("R11 restart beat addr", blog[4], 32'h2200);
  endtask

  task automatic t_autostart();
    logic [31:0] v;
    prep(32'h40);
    put(32'h40, 0, 32'h3000, EOL | 32'd2);
    budget = 5;
    wr(2'd1, 32'h0D);
    repeat (60) @(negedge clk);
    chk("R6 beats", 32'(nb), 32'd5);
    chk("R6 beat after reload", blog[2], 32'h3000);
    chk("R6 beat5", blog[4], 32'h3000);
    chk("R6 fetches", 32'(nf), 32'd6);
    chk("R6 refetch head", flog[4], 32'h40);
    rd(2'd3, v); chk("R6 index back to 0", v, 32'h0000_0001);
    rd(2'd2, v); chk("R10 eol irq active", v, 32'hD);
    wr(2'd2, 32'h1);
    chk("R10 irq cleared", {31'd0, irq}, 32'h0);
    wr(2'd1, 32'h2);
  endtask

  task automatic t_flag_irq();
    logic [31:0] v;
    prep(32'h00);
    put(32'h00, 0, 32'h4000, FLG | 32'd1);
    put(32'h00, 1, 32'h4100, EOL | 32'd1);
    wr(2'd1, 32'h11);
    wait_idle();
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk("R7 flag and eol status", v, 32'h7);
    chk("R10 irq held", {31'd0, irq}, 32'h1);
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk("R10 w1c flag only", v, 32'h1);
    chk("R10 irq low eol masked", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_stop_desc();
    logic [31:0] v;
    prep(32'h40);
    put(32'h40, 0, 32'h5000, STP | 32'd2);
    put(32'h40, 1, 32'h5100, EOL | 32'd5);
    wr(2'd1, 32'h1);
    wait_idle();
    chk("R8 beats", 32'(nb), 32'd2);
    chk("R8 no further fetch", 32'(nf), 32'd2);
    rd(2'd2, v); chk("R8 flag set eol clear", v, 32'h2);
    prep(32'h40);
    put(32'h40, 0, 32'h5200, STP | EOL | 32'd1);
    wr(2'd1, 32'h5);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 stop wins over autostart", 32'(nf), 32'd2);
    rd(2'd2, v); chk("R8 stop+eol status", v, 32'h3);
  endtask

  task automatic t_zero();
    prep(32'h80);
    put(32'h80, 0, 32'h6000, 32'd0);
    put(32'h80, 1, 32'h7000, EOL | 32'd2);
    wr(2'd1, 32'h1);
    wait_idle();
    chk("R9 beats", 32'(nb), 32'd2);
    chk("R9 first beat skips empty", blog[0], 32'h7000);
    chk("R9 fetches", 32'(nf), 32'd4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_two_desc();
    t_stop_write();
    t_autostart();
    t_flag_irq();
    t_stop_desc();
    t_zero();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule